// File: doc/BRIEF.md
# SPI Master Controller with Register Port

This block is a serial peripheral interface master driven by a simple memory-mapped register port. Software turns the controller off, sets the frame length, clock polarity, clock phase, transfer mode and clock divider, picks the target devices through a select mask, and turns it back on. Every word written to the data address then goes into an 8-entry transmit FIFO. The shift engine takes words from that FIFO and shifts them out MSB first on the serial data output. It samples the serial data input into a receive FIFO, which software drains by reading the same data address.

The transfer mode decides what happens to each frame. In transmit-and-receive mode, the word goes out and the received word is kept. In transmit-only mode, received bits are thrown away. In receive-only mode, each queued word acts only as a trigger: the output line stays low and the received bits are kept. The chip-select lines picked by the mask stay low while frames are shifting, including across back-to-back frames. A status register reports FIFO levels, activity and a sticky transmit-overflow error. An interrupt output combines selected status conditions.

Top module: `spi_master_top`

## Requirements
- R1: After reset the enable register reads 0, the control register reads 0x007, all chip selects are high, the serial clock is low, the interrupt is low, and status reads 0x06.
- R2: Writes to the control register (address 1, bits [9:0]) and the baud register (address 2, bits [15:0]) take effect only while the enable register (address 0, bit 0) is 0. While enabled they are ignored. All control bits, including the frame-format field [5:4], read back as written.
- R3: A frame has (control[3:0] + 1) bits. The data word leaves MSB first on mosi_o. The bits sampled from miso_i are stored right-aligned in the receive FIFO, first bit received in the MSB.
- R4: When no frame is shifting, the serial clock rests at the level of control bit 7 (polarity). With control bit 6 (phase) at 0, data is sampled on the leading clock edge and changed on the trailing edge. With phase at 1, data is changed on the leading edge and sampled on the trailing edge.
- R5: Each serial-clock half period lasts (baud >> 1) system clocks. A baud value below 2 keeps the clock idle, and no frame starts.
- R6: The transmit FIFO holds 8 words. A data write (address 6, low 16 bits used) while the FIFO is full is dropped and sets the sticky error flag (status bit 5). Disabling the controller flushes both FIFOs and clears the error. Data writes while disabled are dropped without error.
- R7: Control bits [9:8] select the transfer mode: 0 transmit and receive, 1 transmit only, 2 receive only, 3 treated as 0. In mode 1 the receive FIFO is never written. In mode 2, mosi_o is held low and received frames are stored.
- R8: cs_no[i] is low exactly while the controller is shifting frames and bit i of the select register (address 4) is 1. The line stays low between back-to-back frames taken from a non-empty FIFO.
- R9: Status (address 5) bits are: 0 busy (frame shifting or transmit FIFO not empty), 1 TX not full, 2 TX empty, 3 RX not empty, 4 RX full, 5 transmit error, 6 collision (always 0).
- R10: Reading the data address returns the oldest received word and removes it. Reading it with the receive FIFO empty returns 0.
- R11: irq_o is high when any bit of (mask register at address 3) AND {tx error, RX full, RX not empty, TX empty} is set. Mask bit 0 pairs with TX empty and mask bit 3 with tx error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (pops RX on data address) |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational from address |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_no | output | 4 | Chip selects, active low |
| irq_o | output | 1 | Masked status interrupt |

## Verification
Errors in the shift engine's edge or bit counter show up within the first frame. They appear as a mosi word with wrong bits at the slave's sample edges, a misaligned received word, or a clock half period of the wrong length. A slip in a FIFO pointer or count shows up when the next status read returns wrong level flags, or when a drained word comes out of order. A frame-end condition that drops the active state too early makes the chip-select line rise between back-to-back frames, and this is seen during the same burst.

// File: rtl/spi_master_pkg.sv
`timescale 1ns/1ps
package spi_master_pkg;
  localparam logic [2:0] ADR_EN   = 3'd0;
  localparam logic [2:0] ADR_CTRL = 3'd1;
  localparam logic [2:0] ADR_BAUD = 3'd2;
  localparam logic [2:0] ADR_MASK = 3'd3;
  localparam logic [2:0] ADR_SSEL = 3'd4;
  localparam logic [2:0] ADR_STAT = 3'd5;
  localparam logic [2:0] ADR_DATA = 3'd6;

  localparam int CTRL_W = 10;
  localparam logic [CTRL_W-1:0] CTRL_RST = 10'h007;

  typedef enum logic [1:0] {
    XM_TXRX = 2'd0,
    XM_TXO  = 2'd1,
    XM_RXO  = 2'd2,
    XM_EEP  = 2'd3
  } xfer_mode_e;
endpackage

// File: rtl/spi_fifo.sv
`timescale 1ns/1ps
module spi_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + AW'(1);
  endfunction

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign dout_o  = mem_q[rp_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= nxt(wp_q);
      if (pop_i)  rp_q <= nxt(rp_q);
      if (push_i && !pop_i)      cnt_q <= cnt_q + CW'(1);
      else if (pop_i && !push_i) cnt_q <= cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !flush_i) mem_q[wp_q] <= din_i;
  end

  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (!full_o || pop_i));
  assert_no_underflow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/spi_shifter.sv
`timescale 1ns/1ps
module spi_shifter import spi_master_pkg::*; #(
  parameter int FW   = 16,
  parameter int DIVW = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    cpol_i,
  input  logic                    cpha_i,
  input  logic [$clog2(FW)-1:0]   dfs_i,
  input  logic [DIVW-1:0]         half_i,
  input  xfer_mode_e              mode_i,
  input  logic                    tx_valid_i,
  input  logic [FW-1:0]           tx_data_i,
  output logic                    tx_pop_o,
  output logic                    rx_push_o,
  output logic [FW-1:0]           rx_data_o,
  input  logic                    miso_i,
  output logic                    sclk_o,
  output logic                    mosi_o,
  output logic                    active_o
);
  localparam int EW = $clog2(2 * FW + 1);

  logic            active_q, sclk_q;
  logic [DIVW-1:0] cnt_q;
  logic [EW-1:0]   edge_q, last_e;
  logic [FW-1:0]   tx_sh_q, rx_sh_q;
  logic            tick, done, load, sample, change, go_ok;

  // edges 0..2n-1 toggle sclk, edge 2n is a quiet half period ending the frame
  assign last_e = (EW'(dfs_i) << 1) + EW'(2);
  assign go_ok  = (half_i != '0);
  assign tick   = active_q && (cnt_q == half_i - DIVW'(1));
  assign done   = tick && (edge_q == last_e);
  assign load   = en_i && go_ok && tx_valid_i && (!active_q || done);
  assign sample = tick && (edge_q != last_e) && (edge_q[0] == cpha_i);
  assign change = tick && (cpha_i ? (!edge_q[0] && edge_q != '0 && edge_q != last_e)
                                  : (edge_q[0] && edge_q != last_e - EW'(1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      sclk_q   <= 1'b0;
      cnt_q    <= '0;
      edge_q   <= '0;
      tx_sh_q  <= '0;
      rx_sh_q  <= '0;
    end else if (!en_i) begin
      active_q <= 1'b0;
      sclk_q   <= cpol_i;
      cnt_q    <= '0;
      edge_q   <= '0;
    end else if (load) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      edge_q   <= '0;
      tx_sh_q  <= (mode_i == XM_RXO) ? '0 : tx_data_i;
      rx_sh_q  <= '0;
    end else if (done) begin
      active_q <= 1'b0;
    end else if (active_q) begin
      if (tick) begin
        cnt_q  <= '0;
        edge_q <= edge_q + EW'(1);
        sclk_q <= ~sclk_q;
        if (sample) rx_sh_q <= {rx_sh_q[FW-2:0], miso_i};
        if (change) tx_sh_q <= tx_sh_q << 1;
      end else begin
        cnt_q <= cnt_q + DIVW'(1);
      end
    end else begin
      sclk_q <= cpol_i;
    end
  end

  assign tx_pop_o  = load;
  assign rx_push_o = done && (mode_i != XM_TXO);
  assign rx_data_o = rx_sh_q;
  assign mosi_o    = tx_sh_q[dfs_i];
  assign sclk_o    = sclk_q;
  assign active_o  = active_q;

  assert_idle_level_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_q && $past(!active_q) && $stable(cpol_i)) |-> (sclk_q == cpol_i));
  assert_edge_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (edge_q <= last_e));
  assert_no_div_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (half_i == '0 && !active_q) |=> !active_q);
endmodule

// File: rtl/spi_master_top.sv
`timescale 1ns/1ps
module spi_master_top import spi_master_pkg::*; #(
  parameter int NCS      = 4,
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 8,
  parameter int FW       = 16,
  parameter int DIVW     = 16,
  parameter int RW       = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           reg_we_i,
  input  logic           reg_re_i,
  input  logic [2:0]     reg_addr_i,
  input  logic [RW-1:0]  reg_wdata_i,
  output logic [RW-1:0]  reg_rdata_o,
  output logic           sclk_o,
  output logic           mosi_o,
  input  logic           miso_i,
  output logic [NCS-1:0] cs_no,
  output logic           irq_o
);
  localparam int DFSW = $clog2(FW);
  localparam int MW   = 4;

  logic              en_q, tx_err_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [DIVW-1:0]   baud_q, half;
  logic [MW-1:0]     mask_q;
  logic [NCS-1:0]    ssel_q;

  logic wr_en, wr_ctrl, wr_baud, wr_mask, wr_ssel, wr_data, rd_data;
  logic tx_push, tx_pop, tx_full, tx_empty;
  logic rx_push, rx_pop, rx_full, rx_empty;
  logic sh_rx_push, active, busy;
  logic [FW-1:0] tx_dout, rx_dout, sh_rx_data;
  logic [6:0]    status;
  xfer_mode_e    mode;
  logic          unused_wdata;

  assign unused_wdata = ^reg_wdata_i[RW-1:FW];

  assign wr_en   = reg_we_i && (reg_addr_i == ADR_EN);
  assign wr_ctrl = reg_we_i && (reg_addr_i == ADR_CTRL) && !en_q;
  assign wr_baud = reg_we_i && (reg_addr_i == ADR_BAUD) && !en_q;
  assign wr_mask = reg_we_i && (reg_addr_i == ADR_MASK);
  assign wr_ssel = reg_we_i && (reg_addr_i == ADR_SSEL);
  assign wr_data = reg_we_i && (reg_addr_i == ADR_DATA);
  assign rd_data = reg_re_i && (reg_addr_i == ADR_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      ctrl_q   <= CTRL_RST;
      baud_q   <= '0;
      mask_q   <= '0;
      ssel_q   <= '0;
      tx_err_q <= 1'b0;
    end else begin
      if (wr_en)   en_q   <= reg_wdata_i[0];
      if (wr_ctrl) ctrl_q <= reg_wdata_i[CTRL_W-1:0];
      if (wr_baud) baud_q <= reg_wdata_i[DIVW-1:0];
      if (wr_mask) mask_q <= reg_wdata_i[MW-1:0];
      if (wr_ssel) ssel_q <= reg_wdata_i[NCS-1:0];
      if (!en_q)                         tx_err_q <= 1'b0;
      else if (wr_data && tx_full)       tx_err_q <= 1'b1;
    end
  end

  assign mode    = xfer_mode_e'(ctrl_q[9:8]);
  assign half    = {1'b0, baud_q[DIVW-1:1]};
  assign tx_push = wr_data && en_q && !tx_full;
  assign rx_push = sh_rx_push && !rx_full;
  assign rx_pop  = rd_data && !rx_empty;

  spi_fifo #(.W(FW), .DEPTH(TX_DEPTH)) u_txf (
    .clk_i, .rst_ni, .flush_i(!en_q),
    .push_i(tx_push), .din_i(reg_wdata_i[FW-1:0]),
    .pop_i(tx_pop), .dout_o(tx_dout), .full_o(tx_full), .empty_o(tx_empty));

  spi_fifo #(.W(FW), .DEPTH(RX_DEPTH)) u_rxf (
    .clk_i, .rst_ni, .flush_i(!en_q),
    .push_i(rx_push), .din_i(sh_rx_data),
    .pop_i(rx_pop), .dout_o(rx_dout), .full_o(rx_full), .empty_o(rx_empty));

  spi_shifter #(.FW(FW), .DIVW(DIVW)) u_sh (
    .clk_i, .rst_ni, .en_i(en_q),
    .cpol_i(ctrl_q[7]), .cpha_i(ctrl_q[6]), .dfs_i(ctrl_q[DFSW-1:0]),
    .half_i(half), .mode_i(mode),
    .tx_valid_i(!tx_empty), .tx_data_i(tx_dout), .tx_pop_o(tx_pop),
    .rx_push_o(sh_rx_push), .rx_data_o(sh_rx_data),
    .miso_i, .sclk_o, .mosi_o, .active_o(active));

  assign busy   = active || !tx_empty;
  assign status = {1'b0, tx_err_q, rx_full, !rx_empty, tx_empty, !tx_full, busy};

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign cs_no[i] = !(ssel_q[i] && active);
  end

  assign irq_o = |(mask_q & {tx_err_q, rx_full, !rx_empty, tx_empty});

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      ADR_EN:   reg_rdata_o[0]          = en_q;
      ADR_CTRL: reg_rdata_o[CTRL_W-1:0] = ctrl_q;
      ADR_BAUD: reg_rdata_o[DIVW-1:0]   = baud_q;
      ADR_MASK: reg_rdata_o[MW-1:0]     = mask_q;
      ADR_SSEL: reg_rdata_o[NCS-1:0]    = ssel_q;
      ADR_STAT: reg_rdata_o[6:0]        = status;
      ADR_DATA: reg_rdata_o[FW-1:0]     = rx_empty ? '0 : rx_dout;
      default:  reg_rdata_o             = '0;
    endcase
  end

  assert_cfg_locked_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && $past(en_q)) |-> ($stable(ctrl_q) && $stable(baud_q)));
  assert_err_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_err_q) |-> $past(wr_data && tx_full));
  assert_txo_no_rx_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == XM_TXO) |-> !sh_rx_push);
  assert_cs_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> (&cs_no));
endmodule

// File: tb/sim_spi_master_top.sv
`timescale 1ns/1ps
module sim_spi_master_top;
  localparam logic [2:0] A_EN = 0, A_CTRL = 1, A_BAUD = 2, A_MASK = 3,
                         A_SSEL = 4, A_STAT = 5, A_DATA = 6;
  localparam logic [63:0] MISO_PAT = 64'hC3A5_1F0E_96D2_4B78;

  logic clk = 0, rst_n = 0;
  logic we = 0, re = 0, miso = 0;
  logic [2:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic sclk, mosi, irq;
  logic [3:0] cs_n;

  always #10 clk = ~clk;

  spi_master_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_re_i(re),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso), .cs_no(cs_n), .irq_o(irq));

  int n_chk = 0, n_fail = 0;
  logic [15:0] exp_q[$];
  logic [15:0] rx_q[$];

  logic       m_cpol = 0, m_cpha = 0;
  int         m_n = 8, m_mode = 0, bidx = 0, rxj = 0, nb = 0, cs_rises = 0, n_edge = 0;
  logic [15:0] cap = 0;
  time        t_e0 = 0, t_e1 = 0;
  logic       lead, chg;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic pbit(input int k);
    return MISO_PAT[63 - (k % 64)];
  endfunction

  function automatic logic [15:0] exp_rx(input int j, input int n);
    logic [15:0] v = 0;
    for (int b = 0; b < n; b++) v = {v[14:0], pbit(j * n + b)};
    return v;
  endfunction

  // slave model: samples mosi, drives miso as a continuous bit stream
  always @(sclk) begin
    if (cs_n[1] == 1'b0) begin
      if (n_edge == 0) t_e0 = $time;
      if (n_edge == 1) t_e1 = $time;
      n_edge++;
      lead = (sclk != m_cpol);
      chg  = m_cpha ? lead : !lead;
      if (!chg) begin
        cap = {cap[14:0], mosi};
        nb++;
        if (nb == m_n) begin
          if (exp_q.size() == 0) chk(0, "R3 unexpected frame", {16'h0, cap}, 32'h0);
          else begin
            logic [15:0] e;
            e = exp_q.pop_front();
            chk(cap == e, "R3 mosi frame", {16'h0, cap}, {16'h0, e});
          end
          nb = 0;
          cap = 0;
        end
      end else begin
        miso = pbit(bidx);
        bidx++;
      end
    end
  end

  always @(posedge cs_n[1]) if (rst_n) cs_rises++;

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); re = 1; addr = a; #1 d = rdata;
    @(negedge clk); re = 0;
  endtask

  task automatic set_mode(input logic [9:0] c, input logic [15:0] b);
    wr(A_EN, 0); wr(A_CTRL, {22'h0, c}); wr(A_BAUD, {16'h0, b});
    m_cpol = c[7]; m_cpha = c[6]; m_n = int'(c[3:0]) + 1; m_mode = int'(c[9:8]);
    nb = 0; cap = 0; rxj = 0; n_edge = 0;
    if (!m_cpha) begin miso = pbit(0); bidx = 1; end else bidx = 0;
    wr(A_EN, 1);
  endtask

  task automatic send(input logic [15:0] w);
    logic [15:0] m = 16'hFFFF >> (16 - m_n);
    exp_q.push_back(m_mode == 2 ? 16'h0 : (w & m));
    if (m_mode != 1) begin rx_q.push_back(exp_rx(rxj, m_n)); rxj++; end
    wr(A_DATA, {16'h0, w});
  endtask

  task automatic wait_idle;
    logic [31:0] s;
    for (int i = 0; i < 5000; i++) begin
      rd(A_STAT, s);
      if (!s[0]) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic drain(input string tag);
    logic [31:0] d;
    while (rx_q.size() > 0) begin
      logic [15:0] e;
      e = rx_q.pop_front();
      rd(A_DATA, d);
      chk(d == {16'h0, e}, tag, d, {16'h0, e});
    end
  endtask

  bit done_flag = 0;
  initial begin
    #(200000 * 20);
    if (!done_flag) begin
      chk(0, "watchdog", 0, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // R1 reset state
    rd(A_EN, v);   chk(v == 0, "R1 enable", v, 0);
    rd(A_CTRL, v); chk(v == 32'h007, "R1 ctrl", v, 32'h007);
    rd(A_STAT, v); chk(v == 32'h06, "R1 status", v, 32'h06);
    chk(cs_n == 4'hF, "R1 cs", {28'h0, cs_n}, 32'hF);
    chk(sclk == 0, "R1 sclk", {31'h0, sclk}, 0);
    chk(irq == 0, "R1 irq", {31'h0, irq}, 0);

    // Test 1: 8-bit, mode 0, TX+RX, burst of 8
    wr(A_SSEL, 32'h2);
    set_mode(10'h007, 16'd4);
    wr(A_CTRL, 32'h00F);
    rd(A_CTRL, v); chk(v == 32'h007, "R2 ctrl locked", v, 32'h007);
    cs_rises = 0;
    send(16'h00A5); send(16'h003C); send(16'h00FF); send(16'h0000);
    send(16'h0081); send(16'h005A); send(16'h0096); send(16'h007E);
    rd(A_STAT, v); chk(v[0] == 1, "R9 busy", v, 1);
    chk(cs_n == 4'b1101, "R8 cs select", {28'h0, cs_n}, 32'hD);
    wait_idle;
    chk(t_e1 - t_e0 == 40, "R5 half period baud4", 32'(t_e1 - t_e0), 40);
    chk(cs_rises == 1, "R8 cs held across frames", cs_rises, 1);
    rd(A_STAT, v); chk(v == 32'h1E, "R9 status rx full", v, 32'h1E);
    chk(irq == 0, "R11 irq masked", {31'h0, irq}, 0);
    wr(A_MASK, 32'h2);
    @(negedge clk); chk(irq == 1, "R11 irq rx not empty", {31'h0, irq}, 1);
    drain("R3 rx word");
    rd(A_DATA, v); chk(v == 0, "R10 empty read", v, 0);
    rd(A_STAT, v); chk(v == 32'h06, "R10 status after drain", v, 32'h06);
    chk(irq == 0, "R11 irq cleared", {31'h0, irq}, 0);
    wr(A_MASK, 32'h0);

    // Test 2: 16-bit, cpol1 cpha1
    set_mode(10'h0CF, 16'd6);
    repeat (3) @(negedge clk);
    chk(sclk == 1, "R4 idle high", {31'h0, sclk}, 1);
    send(16'hBEEF); send(16'h1234);
    wait_idle;
    chk(t_e1 - t_e0 == 60, "R5 half period baud6", 32'(t_e1 - t_e0), 60);
    chk(sclk == 1, "R4 idle after frames", {31'h0, sclk}, 1);
    drain("R4 rx word mode3");

    // Test 3: transmit only, 12-bit, cpol0 cpha1
    set_mode(10'h14B, 16'd4);
    send(16'h0ABC); send(16'h05A5);
    wait_idle;
    rd(A_STAT, v); chk(v == 32'h06, "R7 tx-only keeps rx empty", v, 32'h06);

    // Test 4: receive only, 5-bit, cpol1 cpha0
    set_mode(10'h284, 16'd2);
    send(16'h001F); send(16'h0015);
    wait_idle;
    drain("R7 rx-only word");

    // Test 5: divider 0 and TX overflow
    set_mode(10'h007, 16'd0);
    for (int i = 0; i < 9; i++) wr(A_DATA, 32'h55);
    rd(A_STAT, v); chk(v == 32'h21, "R6 full plus error", v, 32'h21);
    repeat (40) @(negedge clk);
    chk(cs_n == 4'hF, "R5 no frame at baud0 cs", {28'h0, cs_n}, 32'hF);
    chk(sclk == 0, "R5 sclk idle at baud0", {31'h0, sclk}, 0);
    wr(A_BAUD, 32'h4);
    rd(A_BAUD, v); chk(v == 0, "R2 baud locked", v, 0);
    wr(A_MASK, 32'h8);
    @(negedge clk); chk(irq == 1, "R11 irq tx error", {31'h0, irq}, 1);
    wr(A_EN, 0);
    rd(A_STAT, v); chk(v == 32'h06, "R6 disable clears", v, 32'h06);
    wr(A_DATA, 32'h1);
    rd(A_STAT, v); chk(v == 32'h06, "R6 write while disabled dropped", v, 32'h06);
    wr(A_CTRL, 32'h037);
    rd(A_CTRL, v); chk(v == 32'h037, "R2 frame format readback", v, 32'h037);
    chk(exp_q.size() == 0, "R3 all frames seen", exp_q.size(), 0);

    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule